// File: doc/BRIEF.md
# Synchronous External Bus Cycle Sequencer

This block is a bus master that turns single read or write requests into external bus cycles. A cycle moves through a fixed chain of clock-wide phases. Each phase is one clock and covers two of the classic half-clock states. The first phase covers S0 and S1. The second covers S2 and S3. Zero or more wait clocks follow. The last phase covers S4 and S5. The sequencer drives the address strobe, the data strobe and the read/write line. It samples a data-transfer acknowledge and a bus error input, one flop per clock.

A small bank of chip-select regions is decoded from the request address. Each region is a base/mask pair with an enable bit, a fast-termination bit and a delay field. A matching region generates its own acknowledge after the number of wait clocks in its delay field. If fast termination is set, the region instead shortens the cycle to two clocks by skipping the S2/S3 phase. In that case the delay field has no effect, and the data strobe stays negated on writes. An address that matches no region waits for the external acknowledge.

A completion pulse returns the error status and, for reads, the captured data.

Top module: `bus_seq`

## Requirements
- R1: After reset, as_n_o and ds_n_o are high, rw_o is high and done_o is low.
- R2: A cycle to an unmatched address whose external acknowledge (ack_n_i low) is present at the second bus clock holds as_n_o low for exactly 3 clocks.
- R3: If the external acknowledge for an unmatched address first appears at bus clock 2+N, wait clocks are inserted and as_n_o stays low for 3+N clocks.
- R4: A matched region with fast termination off acknowledges internally after D wait clocks, where D is its delay field. The cycle lasts 3+D clocks, and ack_n_i has no effect on it.
- R5: A matched region with fast termination on gives a 2-clock cycle whatever its delay field holds, and ack_n_i has no effect on it.
- R6: ds_n_o is low in every bus clock of a read. On a normal write it is low in every bus clock but the first. On a fast-termination write it stays high for the whole cycle.
- R7: rw_o is high for a read and low for a write, and holds its value for the whole cycle. dat_oe_o is high only during write cycles.
- R8: Read data on dat_i is sampled at the last bus clock and presented on rdata_o along with done_o.
- R9: berr_n_i is sampled in the last bus clock, one clock after the acknowledge is taken. If it is low there, err_o is high with done_o. Otherwise err_o is low.
- R10: A region matches when (addr & mask) == (base & mask) and its enable bit is 1. When several regions match, the one with the lowest index wins. A disabled region never matches.
- R11: done_o is a one-clock pulse in the clock after the last bus clock, and as_n_o is high while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a cycle (sampled when idle) |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Request address |
| wdata_i | input | DW | Write data |
| done_o | output | 1 | Cycle complete pulse |
| err_o | output | 1 | Bus error status, valid with done_o |
| rdata_o | output | DW | Captured read data |
| cs_base_i | input | NREG*AW | Region base addresses, region k at bits [k*AW +: AW] |
| cs_mask_i | input | NREG*AW | Region address masks |
| cs_en_i | input | NREG | Region enable bits |
| cs_fast_i | input | NREG | Region fast-termination bits |
| cs_dly_i | input | NREG*DLYW | Region acknowledge delay, in wait clocks |
| addr_o | output | AW | Bus address |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | Read/write line, 1 = read |
| dat_o | output | DW | Bus write data |
| dat_oe_o | output | 1 | Bus data output enable |
| dat_i | input | DW | Bus read data |
| ack_n_i | input | 1 | External transfer acknowledge, active low |
| berr_n_i | input | 1 | Bus error, active low |

## Verification
The bench builds the block with its defaults: two regions, 16-bit address and data, and a 2-bit delay field. With these values every delay setting, 0 to 3, can be swept in both directions and in both termination modes. External acknowledge latencies of 0 to 3 wait clocks are swept for unmatched addresses. The two regions can be made to overlap, which brings the priority rule and a disabled region into the test. Bus error is injected in both a waited normal cycle and a fast-termination cycle.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S01  = 3'd1,
    ST_S23  = 3'd2,
    ST_WAIT = 3'd3,
    ST_S45  = 3'd4
  } bus_st_e;
endpackage

// File: rtl/bus_seq_cs_decode.sv
module bus_seq_cs_decode #(
  parameter int AW   = 16,
  parameter int NREG = 2,
  parameter int DLYW = 2
) (
  input  logic [AW-1:0]        addr_i,
  input  logic [NREG*AW-1:0]   base_i,
  input  logic [NREG*AW-1:0]   mask_i,
  input  logic [NREG-1:0]      en_i,
  input  logic [NREG-1:0]      fast_i,
  input  logic [NREG*DLYW-1:0] dly_i,
  output logic                 hit_o,
  output logic                 fast_o,
  output logic [DLYW-1:0]      dly_o
);
  logic [NREG-1:0] match;

  for (genvar k = 0; k < NREG; k++) begin : g_rgn
    assign match[k] = en_i[k] &&
      ((addr_i & mask_i[k*AW +: AW]) == (base_i[k*AW +: AW] & mask_i[k*AW +: AW]));
  end

  // lowest index wins: scan downward so the last write is the lowest hit
  always_comb begin
    hit_o  = 1'b0;
    fast_o = 1'b0;
    dly_o  = '0;
    for (int k = NREG - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o  = 1'b1;
        fast_o = fast_i[k];
        dly_o  = dly_i[k*DLYW +: DLYW];
      end
    end
  end
endmodule

// File: rtl/bus_seq_ack_timer.sv
module bus_seq_ack_timer #(
  parameter int DLYW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic [DLYW-1:0] dly_i,
  output logic            match_o
);
  logic [DLYW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign match_o = (cnt_q == dly_i);
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int NREG = 2,
  parameter int DLYW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic                 done_o,
  output logic                 err_o,
  output logic [DW-1:0]        rdata_o,
  input  logic [NREG*AW-1:0]   cs_base_i,
  input  logic [NREG*AW-1:0]   cs_mask_i,
  input  logic [NREG-1:0]      cs_en_i,
  input  logic [NREG-1:0]      cs_fast_i,
  input  logic [NREG*DLYW-1:0] cs_dly_i,
  output logic [AW-1:0]        addr_o,
  output logic                 as_n_o,
  output logic                 ds_n_o,
  output logic                 rw_o,
  output logic [DW-1:0]        dat_o,
  output logic                 dat_oe_o,
  input  logic [DW-1:0]        dat_i,
  input  logic                 ack_n_i,
  input  logic                 berr_n_i
);
  bus_st_e         st_q, st_d;
  logic            we_q, hit_q, fast_q;
  logic [DLYW-1:0] dly_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic            done_q, err_q;
  logic            dec_hit, dec_fast;
  logic [DLYW-1:0] dec_dly;
  logic            tmr_match, ack_rec, tmr_adv, accept;

  bus_seq_cs_decode #(.AW(AW), .NREG(NREG), .DLYW(DLYW)) u_dec (
    .addr_i (addr_i),
    .base_i (cs_base_i),
    .mask_i (cs_mask_i),
    .en_i   (cs_en_i),
    .fast_i (cs_fast_i),
    .dly_i  (cs_dly_i),
    .hit_o  (dec_hit),
    .fast_o (dec_fast),
    .dly_o  (dec_dly)
  );

  assign ack_rec = hit_q ? tmr_match : !ack_n_i;
  assign tmr_adv = (st_q == ST_S23 || st_q == ST_WAIT) && !ack_rec;

  bus_seq_ack_timer #(.DLYW(DLYW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (tmr_adv),
    .dly_i   (dly_q),
    .match_o (tmr_match)
  );

  assign accept = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:         if (req_i) st_d = ST_S01;
      ST_S01:          st_d = (hit_q && fast_q) ? ST_S45 : ST_S23;
      ST_S23, ST_WAIT: st_d = ack_rec ? ST_S45 : ST_WAIT;
      ST_S45:          st_d = ST_IDLE;
      default:         st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
      fast_q  <= 1'b0;
      dly_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      if (accept) begin
        we_q    <= we_i;
        hit_q   <= dec_hit;
        fast_q  <= dec_fast;
        dly_q   <= dec_dly;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        err_q   <= 1'b0;
      end
      if (st_q == ST_S45) begin
        done_q <= 1'b1;
        err_q  <= !berr_n_i;
        if (!we_q) rdata_q <= dat_i;
      end
    end
  end

  logic busy;
  assign busy     = (st_q != ST_IDLE);
  assign as_n_o   = !busy;
  assign rw_o     = !busy || !we_q;
  assign ds_n_o   = !busy ? 1'b1 :
                    !we_q ? 1'b0 :
                    (hit_q && fast_q) ? 1'b1 :
                    (st_q == ST_S01);
  assign addr_o   = addr_q;
  assign dat_o    = wdata_q;
  assign dat_oe_o = busy && we_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk
  import bus_seq_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input bus_st_e st_q,
  input logic    hit_q,
  input logic    fast_q,
  input logic    as_n_o,
  input logic    ds_n_o,
  input logic    rw_o,
  input logic    dat_oe_o,
  input logic    done_o
);
  AST_FAST_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_S01 && hit_q && fast_q) |=> (st_q == ST_S45)); // R5
  AST_NORMAL_S23: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_S01 && !(hit_q && fast_q)) |=> (st_q == ST_S23)); // R2
  AST_FAST_WR_NO_DS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_n_o && !rw_o && hit_q && fast_q) |-> ds_n_o); // R6
  AST_RW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_n_o && !$past(as_n_o)) |-> $stable(rw_o)); // R7
  AST_OE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_oe_o |-> (!as_n_o && !rw_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> as_n_o); // R11
  AST_S45_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_S45) |=> (done_o && st_q == ST_IDLE)); // R11
endmodule

bind bus_seq bus_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .st_q     (st_q),
  .hit_q    (hit_q),
  .fast_q   (fast_q),
  .as_n_o   (as_n_o),
  .ds_n_o   (ds_n_o),
  .rw_o     (rw_o),
  .dat_oe_o (dat_oe_o),
  .done_o   (done_o)
);

// File: tb/sim_bus_seq.sv
`timescale 1ns/1ps
module sim_bus_seq;
  localparam int AW = 16, DW = 16, NREG = 2, DLYW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, din = '0;
  logic [NREG*AW-1:0] base = '0, mask = '0;
  logic [NREG-1:0] en = '0, fast = '0;
  logic [NREG*DLYW-1:0] dly = '0;
  logic ack_n = 1'b1, berr_n = 1'b1;
  logic done, err, as_n, ds_n, rw, oe;
  logic [DW-1:0] rdata, dout;
  logic [AW-1:0] aout;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  bus_seq #(.AW(AW), .DW(DW), .NREG(NREG), .DLYW(DLYW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .done_o(done), .err_o(err), .rdata_o(rdata),
    .cs_base_i(base), .cs_mask_i(mask), .cs_en_i(en), .cs_fast_i(fast),
    .cs_dly_i(dly), .addr_o(aout), .as_n_o(as_n), .ds_n_o(ds_n), .rw_o(rw),
    .dat_o(dout), .dat_oe_o(oe), .dat_i(din), .ack_n_i(ack_n), .berr_n_i(berr_n)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic set_rgn(input int k, input logic [AW-1:0] b, input logic [AW-1:0] m,
                         input bit e, input bit f, input int d);
    base[k*AW +: AW]     = b;
    mask[k*AW +: AW]     = m;
    en[k]                = e;
    fast[k]              = f;
    dly[k*DLYW +: DLYW]  = DLYW'(d);
  endtask

  // ext_n: external ack latency in wait clocks; ack_low: hold ack low throughout
  task automatic run(input bit w, input logic [AW-1:0] a, input int ext_n, input bit ack_low,
                     input bit be, input int exp_len, input int exp_ds, input bit exp_err,
                     input string tag);
    int c = 0, dsc = 0, guard = 0;
    bit rwbad = 0, oebad = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = a ^ 16'h0F0F; din = a ^ 16'h5A5A;
    berr_n = !be; ack_n = !ack_low;
    forever begin
      @(negedge clk);
      guard++;
      if (!as_n) begin
        c++;
        req = 1'b0;
        if (!ds_n) dsc++;
        if (rw !== !w) rwbad = 1;
        if (oe !== w) oebad = 1;
        if (!ack_low) ack_n = !(c >= 2 + ext_n);
      end else if (c > 0 || guard > 40) begin
        break;
      end
    end
    chk(c == exp_len, {tag, " length"}, c, exp_len);
    chk(dsc == exp_ds, "R6 ds clocks", dsc, exp_ds);
    chk(!rwbad && !oebad, "R7 rw/oe", int'(rwbad) + 2 * int'(oebad), 0);
    chk(done === 1'b1 && as_n === 1'b1, "R11 done with as negated", int'(done), 1);
    chk(err === exp_err, "R9 err", int'(err), int'(exp_err));
    if (!w) chk(rdata === (a ^ 16'h5A5A), "R8 rdata", int'(rdata), int'(a ^ 16'h5A5A));
    @(negedge clk);
    chk(done === 1'b0, "R11 done pulse", int'(done), 0);
    ack_n = 1'b1; berr_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    set_rgn(0, 16'h1000, 16'hF000, 1, 0, 0);
    set_rgn(1, 16'h2000, 16'hF000, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk(as_n === 1 && ds_n === 1 && rw === 1 && done === 0, "R1 reset",
        int'({as_n, ds_n, rw, done}), 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: unmatched address, external ack after N wait clocks
    for (int w = 0; w < 2; w++)
      for (int n = 0; n < 4; n++)
        run(w[0], 16'h8000 + 16'(n), n, 0, 0, 3 + n, (w != 0) ? 2 + n : 3 + n, 0,
            (n == 0) ? "R2" : "R3");

    // R4: region hit, normal termination, delay d; ack_n held low is ignored
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 4; d++) begin
        set_rgn(0, 16'h1000, 16'hF000, 1, 0, d);
        run(w[0], 16'h1234 + 16'(d), 0, 1, 0, 3 + d, (w != 0) ? 2 + d : 3 + d, 0, "R4");
      end

    // R5 / R6: fast termination ignores delay and external ack
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 4; d++) begin
        set_rgn(1, 16'h2000, 16'hF000, 1, 1, d);
        run(w[0], 16'h2100 + 16'(d), 0, d[0], 0, 2, (w != 0) ? 0 : 2, 0, "R5");
      end

    // R9: bus error in a waited normal read and a fast write
    run(0, 16'h8800, 1, 0, 1, 4, 4, 1, "R9 normal");
    run(1, 16'h2200, 0, 0, 1, 2, 0, 1, "R9 fast");

    // R10: disabled region falls back to external ack
    set_rgn(0, 16'h1000, 16'hF000, 0, 1, 0);
    run(0, 16'h1300, 2, 0, 0, 5, 5, 0, "R10 disabled");

    // R10: overlap, lowest index wins
    set_rgn(0, 16'h1200, 16'hFF00, 1, 1, 0);
    set_rgn(1, 16'h1000, 16'hF000, 1, 0, 3);
    run(0, 16'h1234, 0, 0, 0, 2, 2, 0, "R10 priority");
    set_rgn(0, 16'h1200, 16'hFF00, 0, 1, 0);
    run(0, 16'h1234, 0, 0, 0, 6, 6, 0, "R10 fallback");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule